// File: doc/BRIEF.md
# Per-Lane Variable-Count Vector Shifter

This unit shifts every element of a 256-bit data vector by its own count. The count for each element sits in the element at the same position of a second 256-bit count vector, so neighbouring elements can move by different amounts in the same operation. Elements are either eight 32-bit words or four 64-bit words. Three shift kinds are offered: logical left and logical right for both element sizes, and arithmetic right for 32-bit elements only.

Each count is read as an unsigned number over the full width of its element. Any count at or above the element width gives a defined result rather than wrapping: zero for the logical shifts and a full copy of the sign bit for the arithmetic shift. A narrow mode computes only the low 128 bits and forces the upper 128 result bits to zero. An operation/size pair that the unit does not support is reported on a flag and yields an all-zero result.

The unit has a single register stage. A request presented with `in_valid` high appears on the outputs on the next rising clock edge, together with `out_valid`. When no request is presented, the outputs keep their previous values.

Top module: `vs_shift_unit`

## Requirements
- R1: With `in_op`=00 (logical left) and `in_wide`=0, each 32-bit element i (bits 32i+31..32i) of the result equals data element i shifted left by count element i, with zeros filling the vacated low bits.
- R2: With `in_op`=01 (logical right), each element is shifted right by its own count with zeros filling the vacated high bits. This holds for both element sizes.
- R3: With `in_op`=10 (arithmetic right) and `in_wide`=0, each 32-bit element is shifted right by its own count, and the vacated high bits are filled with that element's bit 31.
- R4: With `in_wide`=1, elements are 64 bits (bits 64i+63..64i). Logical left and logical right then use the 64-bit count element at the same position.
- R5: Every count is an unsigned value over the whole element width. A logical shift whose count is at or above the element width (32 or 64) yields zero for that element, including counts whose low bits alone would be small, such as 0x100 or 2^32.
- R6: An arithmetic shift whose count is 32 or more fills the element with its bit 31.
- R7: With `in_half`=1, result bits 255..128 are zero and bits 127..0 follow R1 to R6.
- R8: The pair `in_op`=10 with `in_wide`=1 is illegal, and so is `in_op`=11 with either size. For either case, `out_illegal` is 1 and the whole result is zero. For a legal request, `out_illegal` is 0.
- R9: The result for a request taken with `in_valid`=1 at a rising edge appears on `out_data` after that edge, with `out_valid`=1. After an edge with `in_valid`=0, `out_valid` is 0 and `out_data` keeps its previous value. Back-to-back requests give back-to-back results.
- R10: While `rst_n` is low, `out_valid`, `out_illegal` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; also the clock enable of the output stage |
| in_data | input | 256 | Data vector to shift |
| in_cnt | input | 256 | Per-element shift counts, packed like the data |
| in_op | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 illegal |
| in_wide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| in_half | input | 1 | 1: 128-bit operation, upper result half zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 256 | Shifted result vector |
| out_illegal | output | 1 | The registered request was an unsupported operation/size pair |

## Verification
The properties assume that reset is asserted from time zero. They also assume that `in_op`, `in_wide`, `in_half` and both vectors hold known values in every cycle where `in_valid` is high, because the registered result and flag are compared against those inputs one edge later. The stimulus changes all inputs only on falling edges and always drives them to defined values, including on idle cycles. The random requests are restricted to legal operation/size pairs, so the illegal combinations are reached only by directed requests whose expected all-zero result is known in advance.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int VEC_W  = 256;
  localparam int ELEM_S = 32;
  localparam int ELEM_L = 64;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_RSV = 2'b11
  } shop_e;
endpackage

// File: rtl/vs_lane.sv
module vs_lane
  import vs_pkg::*;
#(
  parameter int W     = 32,
  parameter bit ARITH = 1'b1
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] c,
  input  shop_e        op,
  output logic [W-1:0] r
);
  localparam int SW = $clog2(W);

  logic          over;
  logic [SW-1:0] amt;
  logic [W-1:0]  sra_val;

  // a count at or above W has some bit set above the low SW bits
  assign over = |c[W-1:SW];
  assign amt  = c[SW-1:0];

  generate
    if (ARITH) begin : g_sra
      always_comb begin
        if (over) sra_val = {W{d[W-1]}};
        else      sra_val = W'($signed(d) >>> amt);
      end
    end else begin : g_no_sra
      assign sra_val = '0;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_SLL:  r = over ? '0 : (d << amt);
      OP_SRL:  r = over ? '0 : (d >> amt);
      OP_SRA:  r = sra_val;
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/vs_out_stage.sv
module vs_out_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_in,
  input  logic         ill_in,
  output logic         v_q,
  output logic [W-1:0] d_q,
  output logic         ill_q
);
  logic         v_nx;
  logic [W-1:0] d_nx;
  logic         ill_nx;

  always_comb begin
    v_nx   = en;
    d_nx   = d_q;
    ill_nx = ill_q;
    if (en) begin
      d_nx   = d_in;
      ill_nx = ill_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      d_q   <= '0;
      ill_q <= 1'b0;
    end else begin
      v_q   <= v_nx;
      d_q   <= d_nx;
      ill_q <= ill_nx;
    end
  end
endmodule

// File: rtl/vs_shift_unit.sv
module vs_shift_unit
  import vs_pkg::*;
#(
  parameter int VW  = vs_pkg::VEC_W,
  parameter int EWS = vs_pkg::ELEM_S,
  parameter int EWL = vs_pkg::ELEM_L
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] in_data,
  input  logic [VW-1:0] in_cnt,
  input  logic [1:0]    in_op,
  input  logic          in_wide,
  input  logic          in_half,
  output logic          out_valid,
  output logic [VW-1:0] out_data,
  output logic          out_illegal
);
  localparam int NS = VW / EWS;
  localparam int NL = VW / EWL;
  localparam int HW = VW / 2;

  shop_e         op;
  logic [VW-1:0] res_s;
  logic [VW-1:0] res_l;
  logic [VW-1:0] res_sel;
  logic [VW-1:0] res_fin;
  logic          bad;

  assign op = shop_e'(in_op);

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_narrow
      vs_lane #(.W(EWS), .ARITH(1'b1)) u_lane (
        .d (in_data[g*EWS +: EWS]),
        .c (in_cnt[g*EWS +: EWS]),
        .op(op),
        .r (res_s[g*EWS +: EWS])
      );
    end
    for (g = 0; g < NL; g++) begin : g_wide
      vs_lane #(.W(EWL), .ARITH(1'b0)) u_lane (
        .d (in_data[g*EWL +: EWL]),
        .c (in_cnt[g*EWL +: EWL]),
        .op(op),
        .r (res_l[g*EWL +: EWL])
      );
    end
  endgenerate

  always_comb begin
    bad     = (op == OP_RSV) || ((op == OP_SRA) && in_wide);
    res_sel = in_wide ? res_l : res_s;
    res_fin = res_sel;
    if (in_half) res_fin[VW-1:HW] = '0;
    if (bad)     res_fin = '0;
  end

  vs_out_stage #(.W(VW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .d_in  (res_fin),
    .ill_in(bad),
    .v_q   (out_valid),
    .d_q   (out_data),
    .ill_q (out_illegal)
  );
endmodule

// File: rtl/vs_shift_unit_chk.sv
module vs_shift_unit_chk #(
  parameter int VW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [VW-1:0] in_data,
  input logic [VW-1:0] in_cnt,
  input logic [1:0]    in_op,
  input logic          in_wide,
  input logic          in_half,
  input logic          out_valid,
  input logic [VW-1:0] out_data,
  input logic          out_illegal
);
  localparam int HW = VW / 2;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_illegal)));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((in_op == 2'b11) || (in_op == 2'b10 && in_wide))) |=> out_illegal);

  p_flag_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_data == '0));

  p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half) |=> (out_data[VW-1:HW] == '0));

  p_big_logical_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && in_op[1] == 1'b0 && in_cnt[31:0] >= 32'd32) |=>
      (out_data[31:0] == 32'd0));

  p_big_arith_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && in_op == 2'b10 && in_cnt[31:0] >= 32'd32) |=>
      (out_data[31:0] == {32{$past(in_data[31])}}));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r10: assert (!out_valid && !out_illegal && out_data == '0);
    end
  end
endmodule

bind vs_shift_unit vs_shift_unit_chk #(.VW(VW)) i_chk (.*);

// File: tb/test_vs_shift_unit.sv
module test_vs_shift_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic [255:0] in_cnt = '0;
  logic [1:0]   in_op = 2'b00;
  logic         in_wide = 1'b0;
  logic         in_half = 1'b0;
  logic         out_valid;
  logic [255:0] out_data;
  logic         out_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [255:0] d;
    logic         ill;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [255:0] last_d = '0;

  always #2 clk = ~clk;

  vs_shift_unit i_vs_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_cnt(in_cnt), .in_op(in_op), .in_wide(in_wide), .in_half(in_half),
    .out_valid(out_valid), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [255:0] model(input logic [255:0] d, input logic [255:0] c,
                                         input logic [1:0] op, input logic wide,
                                         input logic half, output logic ill);
    logic [255:0] r;
    r   = '0;
    ill = (op == 2'b11) || (op == 2'b10 && wide);
    if (!ill) begin
      if (wide) begin
        for (int i = 0; i < 4; i++) begin
          logic [63:0] e, k;
          e = d[i*64 +: 64];
          k = c[i*64 +: 64];
          r[i*64 +: 64] = (op == 2'b00) ? (e << k) : (e >> k);
        end
      end else begin
        for (int i = 0; i < 8; i++) begin
          logic [31:0] e, k;
          e = d[i*32 +: 32];
          k = c[i*32 +: 32];
          case (op)
            2'b00:   r[i*32 +: 32] = e << k;
            2'b01:   r[i*32 +: 32] = e >> k;
            default: r[i*32 +: 32] = $signed(e) >>> k;
          endcase
        end
      end
      if (half) r[255:128] = '0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [255:0] d, input logic [255:0] c, input logic [1:0] op,
                      input logic wide, input logic half, input string tag);
    exp_t e;
    logic il;
    @(negedge clk);
    in_data  = d;
    in_cnt   = c;
    in_op    = op;
    in_wide  = wide;
    in_half  = half;
    in_valid = 1'b1;
    e.d   = model(d, c, op, wide, half, il);
    e.ill = il;
    e.tag = tag;
    last_d = e.d;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compare each result as it leaves the design
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", out_data, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_data == e.d, {e.tag, " data"}, out_data, e.d);
        check(out_illegal == e.ill, {e.tag, " flag"}, 256'(out_illegal), 256'(e.ill));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] d, c;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(out_valid == 1'b0, "R10 valid", 256'(out_valid), '0);
    check(out_illegal == 1'b0, "R10 flag", 256'(out_illegal), '0);
    check(out_data == '0, "R10 data", out_data, '0);
    rst_n = 1'b1;
    idle(2);

    // R1 / R2 / R3: 32-bit lanes, distinct counts per lane
    for (int i = 0; i < 8; i++) begin
      d[i*32 +: 32] = 32'h8000_0001 ^ (32'h0101_0101 * (i + 1));
      c[i*32 +: 32] = 32'(i * 3 + 1);
    end
    send(d, c, 2'b00, 1'b0, 1'b0, "R1 sll32");
    send(d, c, 2'b01, 1'b0, 1'b0, "R2 srl32");
    for (int i = 0; i < 8; i++) begin
      d[i*32 +: 32] = (i % 2 == 0) ? 32'hF000_00F0 + i : 32'h7000_0F00 + i;
      c[i*32 +: 32] = 32'(i * 4);
    end
    send(d, c, 2'b10, 1'b0, 1'b0, "R3 sra32");

    // R4 / R2: 64-bit lanes
    d = {64'h8123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h0000_0001_0000_0001, 64'hDEAD_BEEF_0BAD_F00D};
    c = {64'd0, 64'd1, 64'd31, 64'd63};
    send(d, c, 2'b00, 1'b1, 1'b0, "R4 sll64");
    send(d, c, 2'b01, 1'b1, 1'b0, "R2 srl64");

    // R5: large counts, full-width count interpretation
    c = {32'd32, 32'd33, 32'd255, 32'hFFFF_FFFF, 32'h8000_0000, 32'd31, 32'd0, 32'h100};
    d = {8{32'hA5A5_5A5B}};
    send(d, c, 2'b00, 1'b0, 1'b0, "R5 sll32 big");
    send(d, c, 2'b01, 1'b0, 1'b0, "R5 srl32 big");
    c = {64'd64, 64'h1_0000_0000, 64'h8000_0000_0000_0000, 64'd63};
    send(d, c, 2'b00, 1'b1, 1'b0, "R5 sll64 big");
    send(d, c, 2'b01, 1'b1, 1'b0, "R5 srl64 big");

    // R6: arithmetic with large counts, both signs
    c = {32'd32, 32'hFFFF_FFFF, 32'h8000_0000, 32'd31, 32'd40, 32'h100, 32'd32, 32'd33};
    d = {32'h8000_0000, 32'h7FFF_FFFF, 32'hC000_0001, 32'h4000_0000,
         32'hFFFF_FFFE, 32'h0000_0001, 32'h1234_5678, 32'h9876_5432};
    send(d, c, 2'b10, 1'b0, 1'b0, "R6 sra32 big");

    // R7: 128-bit mode
    for (int i = 0; i < 8; i++) begin
      d[i*32 +: 32] = 32'hCAFE_0000 + 32'(i);
      c[i*32 +: 32] = 32'(i + 2);
    end
    send(d, c, 2'b00, 1'b0, 1'b1, "R7 half sll32");
    send(d, c, 2'b10, 1'b0, 1'b1, "R7 half sra32");
    send(d, {4{64'd5}}, 2'b01, 1'b1, 1'b1, "R7 half srl64");

    // R8: illegal pairs
    send(d, c, 2'b10, 1'b1, 1'b0, "R8 sra64");
    send(d, c, 2'b11, 1'b0, 1'b0, "R8 op3 32");
    send(d, c, 2'b11, 1'b1, 1'b1, "R8 op3 64");
    send(d, c, 2'b00, 1'b0, 1'b0, "R8 legal after illegal");
    idle(2);

    // R9: back-to-back random legal requests
    for (int n = 0; n < 24; n++) begin
      logic [1:0] op;
      logic       w;
      for (int i = 0; i < 8; i++) begin
        d[i*32 +: 32] = $urandom;
        c[i*32 +: 32] = $urandom_range(0, 80);
      end
      op = 2'($urandom_range(0, 2));
      w  = 1'($urandom_range(0, 1));
      if (op == 2'b10 && w) op = 2'b01;
      send(d, c, op, w, 1'($urandom_range(0, 1)), "R9 random");
      if (n % 5 == 4) idle(1);
    end

    // R9: hold after idle
    idle(4);
    check(out_valid == 1'b0, "R9 idle valid", 256'(out_valid), '0);
    check(out_data == last_d, "R9 idle hold", out_data, last_d);
    check(sb.size() == 0, "R9 drained", 256'(sb.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule